// File: doc/BRIEF.md
# Multi-channel MAC address receive router

This block holds a table of 32 MAC address entries and uses it to steer each received frame to receive DMA channels. For every frame the header's destination and source addresses are presented with a strobe. Each valid entry compares one of them against its stored address, skipping any bytes its mask excludes. The lowest-index matching entry gives a 10-bit channel mask. Through that mask, multicast and broadcast frames can be copied to several DMA channels at once.

The table is programmed through two write ports. The direct port writes an entry's address, byte mask, source/destination select, routing flag, primary channel number and valid bit. The indirect port writes an entry's multi-channel select word. When the entry has routing set, its primary channel is merged into that word as a one-hot bit before the word is stored. A global enable decides whether the stored multi-channel selection is used at all.

Top module: `mac_chan_router`

## Requirements
- R1: After reset every entry is invalid and has a zero select word; the outputs are res_vld_o=0, match_o=0, match_idx_o=0 and chan_mask_o=10'h001.
- R2: A frame presented with frm_vld_i high at a clock edge gives its result on the outputs after that edge, with res_vld_o high for exactly that cycle. Without a strobe, match_o, match_idx_o and chan_mask_o hold their values.
- R3: For entries 1 to 31, byte mask bit k (k=0..5) set removes address bits [8k+7:8k] from the comparison. Bit 5 covers bits [47:40].
- R4: For entries 1 to 31, select bit 1 compares the stored address with frm_sa_i and select bit 0 compares it with frm_da_i.
- R5: Entry 0 always compares all 48 bits with frm_da_i, whatever its byte mask and select bit hold.
- R6: When several entries match, match_idx_o is the lowest matching index and the mask comes from that entry.
- R7: When no entry matches, match_o=0 and chan_mask_o=10'h001 (channel 0 only).
- R8: An indirect write of word W to entry i stores W OR (1<<primary channel) if entry i has its routing flag set, and stores W alone otherwise. The entry's routing flag and primary channel are the values held at the time of the write.
- R9: A matching entry outputs its stored select word only when route_en_i is high at the frame strobe and the entry's routing flag is set. Otherwise chan_mask_o=10'h001.
- R10: An entry whose valid bit is clear never matches.
- R11: A direct write whose primary channel is 10 or above is ignored, and the entry keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| route_en_i | input | 1 | Global enable for multi-channel routing |
| wr_en_i | input | 1 | Direct entry write strobe |
| wr_idx_i | input | 5 | Entry index for the direct write |
| wr_addr_i | input | 48 | MAC address to store |
| wr_bmask_i | input | 6 | Byte exclude mask, bit k covers address byte k |
| wr_use_sa_i | input | 1 | 1 compares against the source address, 0 against the destination address |
| wr_route_i | input | 1 | Routing flag of the entry |
| wr_chan_i | input | 4 | Primary channel number (binary) |
| wr_valid_i | input | 1 | Valid bit to store |
| sel_wr_i | input | 1 | Indirect select-word write strobe |
| sel_idx_i | input | 5 | Entry index for the select-word write |
| sel_data_i | input | 10 | One-hot channel select word |
| frm_vld_i | input | 1 | Frame header strobe |
| frm_da_i | input | 48 | Frame destination address |
| frm_sa_i | input | 48 | Frame source address |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| match_o | output | 1 | Some entry matched |
| match_idx_o | output | 5 | Index of the winning entry |
| chan_mask_o | output | 10 | Receive DMA channel mask |

## Verification
A corrupted entry field appears at the ports on the first frame that reaches that entry, and on no earlier frame. A wrong address or byte mask shows as a missed or extra match in the result cycle. A wrong priority shows as a wrong match_idx_o. A bad merge of the select word shows as extra or missing mask bits. The bench therefore sends a frame soon after each programming step. Random frames are aimed at stored addresses, with bytes sometimes corrupted inside or outside the masked positions and with the global enable toggling, so every fault reaches an output within a few frames.

// File: rtl/mac_chan_router_pkg.sv
package mac_chan_router_pkg;
  localparam int ADDR_W  = 48;
  localparam int N_BYTES = ADDR_W / 8;

  typedef struct packed {
    logic               valid;
    logic               use_sa;
    logic [N_BYTES-1:0] bmask;
    logic [ADDR_W-1:0]  addr;
  } addr_ent_t;
endpackage

// File: rtl/mac_chan_router_table.sv
module mac_chan_router_table
  import mac_chan_router_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int N_CHANS   = 10,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int CH_W  = $clog2(N_CHANS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [N_BYTES-1:0] wr_bmask_i,
  input  logic               wr_use_sa_i,
  input  logic               wr_route_i,
  input  logic [CH_W-1:0]    wr_chan_i,
  input  logic               wr_valid_i,
  input  logic               sel_wr_i,
  input  logic [IDX_W-1:0]   sel_idx_i,
  input  logic [N_CHANS-1:0] sel_data_i,
  output addr_ent_t          ent_o   [N_ENTRIES],
  output logic               route_o [N_ENTRIES],
  output logic [N_CHANS-1:0] sel_o   [N_ENTRIES]
);
  localparam logic [CH_W:0] CH_LIMIT = N_CHANS[CH_W:0];

  addr_ent_t          ent_q   [N_ENTRIES];
  logic               route_q [N_ENTRIES];
  logic [CH_W-1:0]    chan_q  [N_ENTRIES];
  logic [N_CHANS-1:0] sel_q   [N_ENTRIES];

  logic               chan_ok;
  logic [N_CHANS-1:0] prim_bit;

  assign chan_ok  = {1'b0, wr_chan_i} < CH_LIMIT;
  // primary channel merged as a one-hot bit on select writes
  assign prim_bit = route_q[sel_idx_i] ? (N_CHANS'(1) << chan_q[sel_idx_i]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        ent_q[i]   <= '0;
        route_q[i] <= 1'b0;
        chan_q[i]  <= '0;
        sel_q[i]   <= '0;
      end
    end else begin
      if (wr_en_i && chan_ok) begin
        ent_q[wr_idx_i]   <= '{valid: wr_valid_i, use_sa: wr_use_sa_i,
                               bmask: wr_bmask_i, addr: wr_addr_i};
        route_q[wr_idx_i] <= wr_route_i;
        chan_q[wr_idx_i]  <= wr_chan_i;
      end
      if (sel_wr_i) sel_q[sel_idx_i] <= sel_data_i | prim_bit;
    end
  end

  assign ent_o   = ent_q;
  assign route_o = route_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/mac_chan_router_match.sv
module mac_chan_router_match
  import mac_chan_router_pkg::*;
#(
  parameter int N_ENTRIES = 32
) (
  input  addr_ent_t              ent_i [N_ENTRIES],
  input  logic [ADDR_W-1:0]      da_i,
  input  logic [ADDR_W-1:0]      sa_i,
  output logic [N_ENTRIES-1:0]   hit_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    if (i == 0) begin : g_full
      // entry 0: full destination compare, mask and select unused
      assign hit_o[i] = ent_i[i].valid && (da_i == ent_i[i].addr);
    end else begin : g_masked
      logic [ADDR_W-1:0]  key;
      logic [N_BYTES-1:0] byte_ok;
      assign key = ent_i[i].use_sa ? sa_i : da_i;
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign byte_ok[b] = ent_i[i].bmask[b] ||
                            (key[8*b +: 8] == ent_i[i].addr[8*b +: 8]);
      end
      assign hit_o[i] = ent_i[i].valid && (&byte_ok);
    end
  end
endmodule

// File: rtl/mac_chan_router_prio.sv
module mac_chan_router_prio #(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    found_o = |hit_i;
    idx_o   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mac_chan_router.sv
module mac_chan_router
  import mac_chan_router_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int N_CHANS   = 10,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int CH_W  = $clog2(N_CHANS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               route_en_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [47:0]        wr_addr_i,
  input  logic [5:0]         wr_bmask_i,
  input  logic               wr_use_sa_i,
  input  logic               wr_route_i,
  input  logic [CH_W-1:0]    wr_chan_i,
  input  logic               wr_valid_i,
  input  logic               sel_wr_i,
  input  logic [IDX_W-1:0]   sel_idx_i,
  input  logic [N_CHANS-1:0] sel_data_i,
  input  logic               frm_vld_i,
  input  logic [47:0]        frm_da_i,
  input  logic [47:0]        frm_sa_i,
  output logic               res_vld_o,
  output logic               match_o,
  output logic [IDX_W-1:0]   match_idx_o,
  output logic [N_CHANS-1:0] chan_mask_o
);
  localparam logic [N_CHANS-1:0] DEF_MASK = N_CHANS'(1);

  addr_ent_t          ent   [N_ENTRIES];
  logic               route [N_ENTRIES];
  logic [N_CHANS-1:0] sel   [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [N_CHANS-1:0] mask_d;

  mac_chan_router_table #(.N_ENTRIES(N_ENTRIES), .N_CHANS(N_CHANS)) u_table (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_idx_i, .wr_addr_i, .wr_bmask_i, .wr_use_sa_i,
    .wr_route_i, .wr_chan_i, .wr_valid_i,
    .sel_wr_i, .sel_idx_i, .sel_data_i,
    .ent_o(ent), .route_o(route), .sel_o(sel)
  );

  mac_chan_router_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .ent_i(ent), .da_i(frm_da_i), .sa_i(frm_sa_i), .hit_o(hit)
  );

  mac_chan_router_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .hit_i(hit), .found_o(found), .idx_o(win_idx)
  );

  assign mask_d = (found && route_en_i && route[win_idx]) ? sel[win_idx] : DEF_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o   <= 1'b0;
      match_o     <= 1'b0;
      match_idx_o <= '0;
      chan_mask_o <= DEF_MASK;
    end else begin
      res_vld_o <= frm_vld_i;
      if (frm_vld_i) begin
        match_o     <= found;
        match_idx_o <= win_idx;
        chan_mask_o <= mask_d;
      end
    end
  end
endmodule

// File: rtl/mac_chan_router_chk.sv
module mac_chan_router_chk #(
  parameter int N_ENTRIES = 32,
  parameter int N_CHANS   = 10,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               route_en_i,
  input logic               frm_vld_i,
  input logic               res_vld_o,
  input logic               match_o,
  input logic [IDX_W-1:0]   match_idx_o,
  input logic [N_CHANS-1:0] chan_mask_o
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!res_vld_o && !match_o && chan_mask_o == N_CHANS'(1));
    end
  end

  // R2
  res_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> res_vld_o);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> !res_vld_o);

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> ($stable(chan_mask_o) && $stable(match_o) && $stable(match_idx_o)));

  // R7
  miss_default_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !match_o) |-> (chan_mask_o == N_CHANS'(1)));

  // R9
  global_off_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !route_en_i) |=> (chan_mask_o == N_CHANS'(1)));
endmodule

bind mac_chan_router mac_chan_router_chk #(.N_ENTRIES(N_ENTRIES), .N_CHANS(N_CHANS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .route_en_i(route_en_i), .frm_vld_i(frm_vld_i),
  .res_vld_o(res_vld_o), .match_o(match_o), .match_idx_o(match_idx_o),
  .chan_mask_o(chan_mask_o)
);

// File: tb/mac_chan_router_tb.sv
module mac_chan_router_tb;
  localparam int NE = 32;
  localparam int NC = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        route_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [47:0] wr_addr_i = '0;
  logic [5:0]  wr_bmask_i = '0;
  logic        wr_use_sa_i = 1'b0;
  logic        wr_route_i = 1'b0;
  logic [3:0]  wr_chan_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        sel_wr_i = 1'b0;
  logic [4:0]  sel_idx_i = '0;
  logic [9:0]  sel_data_i = '0;
  logic        frm_vld_i = 1'b0;
  logic [47:0] frm_da_i = '0;
  logic [47:0] frm_sa_i = '0;
  logic        res_vld_o, match_o;
  logic [4:0]  match_idx_o;
  logic [9:0]  chan_mask_o;

  mac_chan_router u_dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [47:0] m_addr [NE];
  logic [5:0]  m_bm   [NE];
  logic        m_sa   [NE];
  logic        m_val  [NE];
  logic        m_rt   [NE];
  logic [3:0]  m_ch   [NE];
  logic [9:0]  m_sel  [NE];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ent_hit(int i, logic [47:0] da, logic [47:0] sa);
    logic [47:0] k;
    if (!m_val[i]) return 1'b0;
    if (i == 0) return da == m_addr[0];
    k = m_sa[i] ? sa : da;
    for (int b = 0; b < 6; b++)
      if (!m_bm[i][b] && k[8*b +: 8] != m_addr[i][8*b +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic write_ent(int idx, logic [47:0] a, logic [5:0] bm, logic sa,
                           logic rt, logic [3:0] ch, logic v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 5'(idx); wr_addr_i = a; wr_bmask_i = bm;
    wr_use_sa_i = sa; wr_route_i = rt; wr_chan_i = ch; wr_valid_i = v;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    if (ch < 4'(NC)) begin
      m_addr[idx] = a; m_bm[idx] = bm; m_sa[idx] = sa;
      m_rt[idx] = rt; m_ch[idx] = ch; m_val[idx] = v;
    end
  endtask

  task automatic write_sel(int idx, logic [9:0] d);
    @(negedge clk_i);
    sel_wr_i = 1'b1; sel_idx_i = 5'(idx); sel_data_i = d;
    @(posedge clk_i);
    #1 sel_wr_i = 1'b0;
    m_sel[idx] = d | (m_rt[idx] ? (10'd1 << m_ch[idx]) : 10'd0);
  endtask

  // sends a frame and checks all outputs against the model
  task automatic send(string req, logic [47:0] da, logic [47:0] sa);
    logic found; int widx; logic [9:0] emask;
    found = 1'b0; widx = 0;
    for (int i = NE - 1; i >= 0; i--)
      if (ent_hit(i, da, sa)) begin found = 1'b1; widx = i; end
    emask = (found && route_en_i && m_rt[widx]) ? m_sel[widx] : 10'd1;
    @(negedge clk_i);
    frm_vld_i = 1'b1; frm_da_i = da; frm_sa_i = sa;
    @(negedge clk_i);
    frm_vld_i = 1'b0;
    chk({req, " res_vld"}, 32'(res_vld_o), 32'd1);
    chk({req, " match"}, 32'(match_o), 32'(found));
    if (found) chk({req, " idx"}, 32'(match_idx_o), 32'(widx));
    chk({req, " mask"}, 32'(chan_mask_o), 32'(emask));
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, da, sa;
    int j;
    void'($urandom(32'd4242));
    for (int i = 0; i < NE; i++) begin
      m_addr[i] = '0; m_bm[i] = '0; m_sa[i] = 0; m_val[i] = 0;
      m_rt[i] = 0; m_ch[i] = '0; m_sel[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 res_vld", 32'(res_vld_o), 0);
    chk("R1 match", 32'(match_o), 0);
    chk("R1 idx", 32'(match_idx_o), 0);
    chk("R1 mask", 32'(chan_mask_o), 32'h1);
    rst_ni = 1'b1;
    // R1, R10: empty table matches nothing, even an all-zero address
    send("R1 R10 empty", 48'h0, 48'h0);

    route_en_i = 1'b1;
    // R5: entry 0 ignores mask and SA select
    write_ent(0, 48'h0102_0304_0506, 6'h3F, 1'b1, 1'b1, 4'd2, 1'b1);
    write_sel(0, 10'h300);
    chk("R8 merge", 32'(m_sel[0]), 32'h304);
    send("R5 full DA", 48'h0102_0304_0506, 48'h0);
    send("R5 byte differs", 48'h0102_0304_0507, 48'h0);
    send("R5 SA ignored", 48'h0, 48'h0102_0304_0506);
    // R3: masked top byte
    write_ent(3, 48'hAA11_2233_4455, 6'b100000, 1'b0, 1'b1, 4'd9, 1'b1);
    write_sel(3, 10'h001);
    send("R3 masked byte5", 48'h5511_2233_4455, 48'h0);
    send("R3 unmasked byte0", 48'hAA11_2233_4456, 48'h0);
    // R4: SA compare
    write_ent(5, 48'hFFFF_FFFF_FFFF, 6'h0, 1'b1, 1'b1, 4'd4, 1'b1);
    write_sel(5, 10'h022);
    send("R4 SA match", 48'h0, 48'hFFFF_FFFF_FFFF);
    send("R4 DA not used", 48'hFFFF_FFFF_FFFF, 48'h0);
    // R6: priority, entries 7 and 9 both hit
    write_ent(9, 48'h0000_0000_0077, 6'h0, 1'b0, 1'b1, 4'd1, 1'b1);
    write_ent(7, 48'h0000_0000_0077, 6'h0, 1'b0, 1'b1, 4'd6, 1'b1);
    write_sel(9, 10'h000);
    write_sel(7, 10'h200);
    send("R6 lowest wins", 48'h0000_0000_0077, 48'h0);
    // R10: invalidate 7, 9 wins
    write_ent(7, 48'h0000_0000_0077, 6'h0, 1'b0, 1'b1, 4'd6, 1'b0);
    send("R10 invalid skipped", 48'h0000_0000_0077, 48'h0);
    // R8: no routing flag, primary not merged
    write_ent(11, 48'h1234_5678_9ABC, 6'h0, 1'b0, 1'b0, 4'd3, 1'b1);
    write_sel(11, 10'h010);
    chk("R8 no merge", 32'(m_sel[11]), 32'h010);
    send("R8 R9 route off entry", 48'h1234_5678_9ABC, 48'h0);
    // R9: global enable off
    route_en_i = 1'b0;
    send("R9 global off", 48'h0102_0304_0506, 48'h0);
    route_en_i = 1'b1;
    send("R9 global on", 48'h0102_0304_0506, 48'h0);
    // R11: illegal primary channel ignored
    write_ent(5, 48'h0BAD_0BAD_0BAD, 6'h0, 1'b0, 1'b1, 4'd12, 1'b1);
    send("R11 old kept", 48'h0, 48'hFFFF_FFFF_FFFF);
    send("R11 new absent", 48'h0BAD_0BAD_0BAD, 48'h0);
    // R7: miss
    send("R7 miss", 48'hDEAD_BEEF_0000, 48'hDEAD_BEEF_0000);

    // random table
    for (int i = 0; i < NE; i++) begin
      a = {$urandom, $urandom};
      write_ent(i, a, 6'($urandom & $urandom & $urandom), 1'($urandom),
                1'($urandom), 4'($urandom % NC), ($urandom % 4) != 0);
      write_sel(i, 10'($urandom));
    end
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) route_en_i = 1'($urandom);
      da = {$urandom, $urandom}; sa = {$urandom, $urandom};
      j = int'($urandom % NE);
      if (m_sa[j] && j != 0) sa = m_addr[j]; else da = m_addr[j];
      if ($urandom % 3 == 0) begin
        int b; b = int'($urandom % 6);
        da[8*b +: 8] = da[8*b +: 8] ^ 8'h5A;
        sa[8*b +: 8] = sa[8*b +: 8] ^ 8'hA5;
      end
      send("R3 R4 R6 R9 random", da, sa);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule